// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel. Software programs four values through a plain register write port: a 16-bit control word, a 20-bit source pointer, a 20-bit destination pointer and a 16-bit transfer count. Once the control word has its arm bit set, the channel moves data one transfer at a time. Each transfer is a read cycle at the source pointer followed by a write cycle at the destination pointer, which carries the data just read. Both cycles go out on a request/acknowledge bus. Every cycle is tagged with its address space (memory or I/O) and its size (byte or word).

After each transfer, the block steps each pointer according to that pointer's own increment and decrement bits and lowers the count by one. It then decides whether the channel goes on, stops and disarms itself, or stops and raises an interrupt. Transfers can run freely, or they can be paced by a one-bit external request input. An internal-request bit overrides the pacing selection and makes the channel run freely.

The bus side follows valid/ready rules. `bus_req` acts as valid and `bus_ack` as ready. A cycle completes on the clock edge where both are high. While `bus_req` is high and `bus_ack` is low, the block holds the address, direction, tags and write data steady. The block never withdraws a request, so the bus may stall it for any number of cycles. The register port and the pacing input are plain control pins.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle with `bus_req`, `busy` and `irq` low. The reset control word is 16'h00C0, which selects the idle-forever pacing code and leaves the arm bit clear, so no transfer starts even while `dma_req` is high.
- R2: `cfg_sel` picks the target of a register write: 0 = control, 1 = source pointer, 2 = destination pointer, 3 = count. A write is taken only while the channel is idle (`busy` low). A write issued while busy has no effect on the pointers used by later cycles.
- R3: Each transfer issues a read cycle (`bus_write`=0) at the source pointer, then a write cycle (`bus_write`=1) at the destination pointer whose `bus_wdata` equals the `bus_rdata` accepted in that read. While `bus_req` waits for `bus_ack`, the address, direction, tags and data stay stable.
- R4: `bus_is_word` equals control bit 0 (1 = word, 0 = byte). `bus_is_mem` equals control bit 12 on reads and control bit 15 on writes (1 = memory, 0 = I/O).
- R5: After each transfer, the source pointer steps by control bits 10 (up) and 11 (down), and the destination pointer by bits 13 (up) and 14 (down). The step is 2 for word and 1 for byte transfers. A pointer whose up and down bits are equal keeps its value. Pointers wrap modulo 2^20.
- R6: Control bits 7:6 select pacing: 00 = free-running, 01 = source-paced, 10 = destination-paced, 11 = idle forever. When control bit 4 (internal request) is 1, bits 7:6 and `dma_req` are ignored and the channel runs free-running.
- R7: Control bit 1 arms the channel. In a paced mode, a transfer starts only when the armed channel sees `dma_req` high, after a one-cycle sampling register.
- R8: The count drops by one per transfer. A free-running channel starts only with a nonzero count and always stops when the count reaches zero, whatever control bit 9 holds.
- R9: In a paced mode with control bit 9 set, the channel stops when the count reaches zero and does not start from zero. With bit 9 clear, it continues past zero as long as `dma_req` stays high, and the count wraps.
- R10: Stopping at zero clears the arm bit. The channel then stays idle, even with `dma_req` high or a new count loaded, until the control word is written with arm set again.
- R11: `irq` pulses high for exactly one cycle when the channel stops at zero with control bits 9 and 8 both set. It never pulses otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 source, 2 destination, 3 count) |
| cfg_wdata | input | 20 | Register write value (control and count use the low 16 bits) |
| dma_req | input | 1 | External pacing request |
| bus_req | output | 1 | Bus cycle valid |
| bus_ack | input | 1 | Bus cycle ready; completes the cycle with bus_req |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 20 | Cycle address |
| bus_is_mem | output | 1 | 1 = memory space, 0 = I/O space |
| bus_is_word | output | 1 | 1 = word, 0 = byte |
| bus_wdata | output | 16 | Write data (data captured from the preceding read) |
| bus_rdata | input | 16 | Read data, taken with bus_ack on a read cycle |
| busy | output | 1 | Channel is inside a transfer |
| irq | output | 1 | One-cycle interrupt pulse at terminal count |

## Verification
A pointer that steps wrongly shows at the very next read or write cycle as an address that disagrees with the bench's own pointer model. A corrupted count or a wrong stop decision shows as a transfer too many or too few, visible within one idle window after the job should have ended. It can also show as an `irq` pulse that appears or goes missing in the cycle after the final write. A bad hold on a stalled cycle, or lost read data, shows in the same cycle as a changed address or a `bus_wdata` that differs from the value the bench returned on the read.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // control word bit positions
  localparam int unsigned B_DMEM = 15;
  localparam int unsigned B_DDEC = 14;
  localparam int unsigned B_DINC = 13;
  localparam int unsigned B_SMEM = 12;
  localparam int unsigned B_SDEC = 11;
  localparam int unsigned B_SINC = 10;
  localparam int unsigned B_TC   = 9;
  localparam int unsigned B_IEN  = 8;
  localparam int unsigned B_SYNH = 7;
  localparam int unsigned B_SYNL = 6;
  localparam int unsigned B_SELF = 4;
  localparam int unsigned B_ARM  = 1;
  localparam int unsigned B_WORD = 0;

  localparam int unsigned CTRL_W   = 16;
  localparam logic [15:0] CTRL_RST = 16'h00C0;

  typedef enum logic [1:0] {
    SYNC_FREE = 2'b00,
    SYNC_SRC  = 2'b01,
    SYNC_DST  = 2'b10,
    SYNC_OFF  = 2'b11
  } sync_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } st_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          up,
  input  logic          down,
  input  logic          word,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] step;
  logic [AW-1:0] ptr_nxt;

  always_comb begin
    step = word ? TWO : ONE;
    if (up && !down)      ptr_nxt = ptr + step;
    else if (down && !up) ptr_nxt = ptr - step;
    else                  ptr_nxt = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (step_en) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  output logic          is_zero,
  output logic          is_last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (dec_en) cnt <= cnt - ONE;
  end

  assign is_zero = (cnt == '0);
  assign is_last = (cnt == ONE);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic       arm,
  input  logic       self_req,
  input  logic [1:0] sync_sel,
  input  logic       tc_en,
  input  logic       irq_en,
  input  logic       dreq_q,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       bus_ack,
  output st_e        state,
  output logic       upd,
  output logic       stop,
  output logic       irq
);
  st_e  st_nxt;
  logic free_run;
  logic parked;
  logic can_go;

  // internal request overrides the pacing code
  assign free_run = self_req || (sync_e'(sync_sel) == SYNC_FREE);
  assign parked   = !self_req && (sync_e'(sync_sel) == SYNC_OFF);

  always_comb begin
    if (parked)        can_go = 1'b0;
    else if (free_run) can_go = !cnt_zero;
    else               can_go = dreq_q && (!tc_en || !cnt_zero);
  end

  always_comb begin
    st_nxt = state;
    upd    = 1'b0;
    unique case (state)
      ST_IDLE: if (!cfg_wr_en && arm && can_go) st_nxt = ST_RD;
      ST_RD:   if (bus_ack) st_nxt = ST_WR;
      ST_WR:   if (bus_ack) st_nxt = ST_UPD;
      ST_UPD: begin
        upd    = 1'b1;
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign stop = upd && cnt_last && (free_run || tc_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= st_nxt;
      irq   <= stop && tc_en && irq_en;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  localparam int unsigned FW = (AW > CW) ? ((AW > CTRL_W) ? AW : CTRL_W)
                                         : ((CW > CTRL_W) ? CW : CTRL_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_sel,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          dma_req,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_is_mem,
  output logic          bus_is_word,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          irq
);
  st_e              state;
  logic             reg_wr;
  logic [15:0]      ctrl_q;
  logic             dreq_q;
  logic [DW-1:0]    data_q;
  logic             upd;
  logic             stop;
  logic             cnt_zero;
  logic             cnt_last;
  logic [AW-1:0]    ptr_q [2];
  logic             unused_ctrl;

  assign reg_wr      = cfg_wr_en && (state == ST_IDLE);
  assign unused_ctrl = ^{ctrl_q[5], ctrl_q[3:2], cfg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctrl_q <= CTRL_RST;
    else if (reg_wr && cfg_sel == SEL_CTRL) ctrl_q <= cfg_wdata[15:0];
    else if (stop)                         ctrl_q[B_ARM] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      data_q <= '0;
    end else begin
      dreq_q <= dma_req;
      if (state == ST_RD && bus_ack) data_q <= bus_rdata;
    end
  end

  // index 0 = source pointer, index 1 = destination pointer
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    localparam int unsigned UP_B = (g == 0) ? B_SINC : B_DINC;
    localparam int unsigned DN_B = (g == 0) ? B_SDEC : B_DDEC;
    localparam logic [1:0]  SEL  = (g == 0) ? SEL_SRC : SEL_DST;
    dma_ptr_unit #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reg_wr && cfg_sel == SEL),
      .load_val (cfg_wdata[AW-1:0]),
      .step_en  (upd),
      .up       (ctrl_q[UP_B]),
      .down     (ctrl_q[DN_B]),
      .word     (ctrl_q[B_WORD]),
      .ptr      (ptr_q[g])
    );
  end

  dma_cnt_unit #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reg_wr && cfg_sel == SEL_CNT),
    .load_val (cfg_wdata[CW-1:0]),
    .dec_en   (upd),
    .is_zero  (cnt_zero),
    .is_last  (cnt_last)
  );

  dma_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .arm       (ctrl_q[B_ARM]),
    .self_req  (ctrl_q[B_SELF]),
    .sync_sel  (ctrl_q[B_SYNH:B_SYNL]),
    .tc_en     (ctrl_q[B_TC]),
    .irq_en    (ctrl_q[B_IEN]),
    .dreq_q    (dreq_q),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .bus_ack   (bus_ack),
    .state     (state),
    .upd       (upd),
    .stop      (stop),
    .irq       (irq)
  );

  assign bus_req     = (state == ST_RD) || (state == ST_WR);
  assign bus_write   = (state == ST_WR);
  assign bus_addr    = bus_write ? ptr_q[1] : ptr_q[0];
  assign bus_is_mem  = bus_write ? ctrl_q[B_DMEM] : ctrl_q[B_SMEM];
  assign bus_is_word = ctrl_q[B_WORD];
  assign bus_wdata   = data_q;
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          bus_is_mem,
  input logic          bus_is_word,
  input logic [DW-1:0] bus_wdata,
  input logic          busy,
  input logic          irq,
  input logic [15:0]   ctrl_q
);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)
                               && $stable(bus_is_mem) && $stable(bus_is_word)
                               && $stable(bus_wdata)));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_write) |=> (bus_req && bus_write));

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(ctrl_q[9]) && $past(ctrl_q[8])));

  // R6
  no_park_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctrl_q[4]) || ($past(ctrl_q[7:6]) != 2'b11)));

  // R7
  armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_q[1]));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_ack     (bus_ack),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_is_mem  (bus_is_mem),
  .bus_is_word (bus_is_word),
  .bus_wdata   (bus_wdata),
  .busy        (busy),
  .irq         (irq),
  .ctrl_q      (ctrl_q)
);

// File: tb/test_dma_chan_seq.sv
`timescale 1ns/1ps
module test_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [19:0] cfg_wdata = '0;
  logic        dma_req = 1'b0;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic        bus_write;
  logic [19:0] bus_addr;
  logic        bus_is_mem;
  logic        bus_is_word;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        busy;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  int n_xfer = 0;
  int n_irq = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;
  logic [15:0] m_ctrl = '0;
  logic [19:0] m_src = '0;
  logic [19:0] m_dst = '0;

  always #2.5 clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dma_req(dma_req), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_is_mem(bus_is_mem), .bus_is_word(bus_is_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
  );

  function automatic logic [15:0] rd_fn(logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A3};
  endfunction

  function automatic logic [19:0] nxt_ptr(logic [19:0] p, logic up, logic dn, logic w);
    logic [19:0] s;
    s = w ? 20'd2 : 20'd1;
    if (up && !dn) return p + s;
    if (dn && !up) return p - s;
    return p;
  endfunction

  // control word: dmem ddec dinc smem sdec sinc tc ien sync self arm word
  function automatic logic [15:0] mk_ctrl(bit dm, bit dd, bit di, bit sm, bit sd, bit si,
                                          bit tc, bit ie, logic [1:0] sy, bit sf, bit ar, bit w);
    return {dm, dd, di, sm, sd, si, tc, ie, sy, 1'b0, sf, 2'b00, ar, w};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [19:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic load_job(logic [15:0] c, logic [19:0] s, logic [19:0] d, logic [15:0] n);
    wr_reg(2'd1, s);
    wr_reg(2'd2, d);
    wr_reg(2'd3, {4'h0, n});
    m_src = s; m_dst = d; m_ctrl = c;
    wr_reg(2'd0, {4'h0, c});
  endtask

  task automatic finish_job(int base_x, int base_i, int exp_x, int exp_i, string req);
    for (int i = 0; i < 4000 && !((n_xfer - base_x) >= exp_x && !busy); i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk((n_xfer - base_x) == exp_x, req, "transfer count", n_xfer - base_x, exp_x);
    chk((n_irq - base_i) == exp_i, "R11", "irq pulses", n_irq - base_i, exp_i);
  endtask

  task automatic run_job(logic [15:0] c, logic [19:0] s, logic [19:0] d, logic [15:0] n,
                         int exp_x, int exp_i, string req);
    int bx;
    int bi;
    bx = n_xfer; bi = n_irq;
    load_job(c, s, d, n);
    finish_job(bx, bi, exp_x, exp_i, req);
  endtask

  // bus responder and per-cycle checker
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) bus_ack = 1'b0;
      else if (bus_ack) bus_ack = 1'b0;
      else if (bus_req && ($urandom_range(2) != 0)) begin
        chk(bus_is_word == m_ctrl[0], "R4", "size tag", bus_is_word, m_ctrl[0]);
        if (!bus_write) begin
          chk(bus_addr == m_src, "R5", "read address", bus_addr, m_src);
          chk(bus_is_mem == m_ctrl[12], "R4", "read space", bus_is_mem, m_ctrl[12]);
          bus_rdata = rd_fn(bus_addr);
          rd_seen = 1'b1;
        end else begin
          chk(rd_seen, "R3", "read before write", 0, 1);
          chk(bus_addr == m_dst, "R5", "write address", bus_addr, m_dst);
          chk(bus_is_mem == m_ctrl[15], "R4", "write space", bus_is_mem, m_ctrl[15]);
          chk(bus_wdata == rd_fn(m_src), "R3", "write data", bus_wdata, rd_fn(m_src));
          m_src = nxt_ptr(m_src, m_ctrl[10], m_ctrl[11], m_ctrl[0]);
          m_dst = nxt_ptr(m_dst, m_ctrl[13], m_ctrl[14], m_ctrl[0]);
          rd_seen = 1'b0;
          n_xfer++;
        end
        bus_ack = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq) n_irq++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not end, got %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int bx;
    int bi;
    int bb;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req, "R1", "bus_req after reset", bus_req, 0);
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!irq, "R1", "irq after reset", irq, 0);
    dma_req = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_xfer == 0, "R1", "no transfer from reset", n_xfer, 0);
    dma_req = 1'b0;

    // R8: free-running, TC clear, stops at zero anyway; no irq since TC clear
    run_job(mk_ctrl(1,0,1,1,0,1, 0,1, 2'b00, 0,1,1), 20'h01000, 20'h02000, 16'd4, 4, 0, "R8");

    // R10: disarmed after stop, new count does nothing
    bx = n_xfer;
    dma_req = 1'b1;
    wr_reg(2'd3, 20'd3);
    repeat (40) @(negedge clk);
    chk(n_xfer == bx, "R10", "idle after stop", n_xfer - bx, 0);
    // R10: re-arm resumes from current pointers
    m_ctrl = mk_ctrl(1,0,1,1,0,1, 0,1, 2'b00, 0,1,1);
    bi = n_irq;
    wr_reg(2'd0, {4'h0, m_ctrl});
    finish_job(bx, bi, 3, 0, "R10");
    dma_req = 1'b0;

    // R5: byte, source down, destination held (both bits set); R11 irq with TC and INT
    run_job(mk_ctrl(0,1,1,1,1,0, 1,1, 2'b00, 0,1,0), 20'h00010, 20'h00300, 16'd3, 3, 1, "R5");

    // R5: wrap both ways with word step
    run_job(mk_ctrl(1,1,0,0,0,1, 1,0, 2'b00, 0,1,1), 20'hFFFFE, 20'h00000, 16'd2, 2, 0, "R5");

    // R8: zero count never starts in free-running mode
    run_job(mk_ctrl(1,0,1,1,0,1, 1,1, 2'b00, 0,1,1), 20'h00100, 20'h00200, 16'd0, 0, 0, "R8");
    wr_reg(2'd0, 20'h0);

    // R7: source-paced waits for request
    bx = n_xfer; bi = n_irq;
    load_job(mk_ctrl(1,0,1,1,0,1, 1,1, 2'b01, 0,1,1), 20'h04000, 20'h05000, 16'd2);
    repeat (40) @(negedge clk);
    chk(n_xfer == bx, "R7", "no transfer without request", n_xfer - bx, 0);
    dma_req = 1'b1;
    // R9: TC set stops at zero with irq
    finish_job(bx, bi, 2, 1, "R9");
    dma_req = 1'b0;

    // R9: destination-paced with TC clear runs past zero
    bx = n_xfer; bi = n_irq;
    load_job(mk_ctrl(1,0,1,0,0,1, 0,1, 2'b10, 0,1,1), 20'h06000, 20'h07000, 16'd2);
    dma_req = 1'b1;
    for (int i = 0; i < 4000 && (n_xfer - bx) < 5; i++) @(negedge clk);
    dma_req = 1'b0;
    repeat (40) @(negedge clk);
    chk((n_xfer - bx) >= 5, "R9", "continues past zero", n_xfer - bx, 5);
    chk(!busy, "R9", "stops when request drops", busy, 0);
    chk(n_irq == bi, "R11", "no irq with TC clear", n_irq - bi, 0);
    wr_reg(2'd0, 20'h0);

    // R6: pacing code 11 stays idle
    bx = n_xfer;
    load_job(mk_ctrl(1,0,1,1,0,1, 1,1, 2'b11, 0,1,1), 20'h08000, 20'h09000, 16'd3);
    dma_req = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_xfer == bx, "R6", "parked code idle", n_xfer - bx, 0);
    dma_req = 1'b0;
    wr_reg(2'd0, 20'h0);

    // R6: internal request overrides code 11 and ignores dma_req
    run_job(mk_ctrl(0,0,1,0,0,1, 0,1, 2'b11, 1,1,0), 20'h0A000, 20'h0B000, 16'd2, 2, 0, "R6");

    // R2: write during a running job is dropped
    bb = n_bad; bx = n_xfer; bi = n_irq;
    load_job(mk_ctrl(1,0,1,1,0,1, 0,0, 2'b00, 0,1,1), 20'h0C000, 20'h0D000, 16'd6);
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 2'd1; cfg_wdata = 20'h00F00;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    finish_job(bx, bi, 6, 0, "R2");
    chk(n_bad == bb, "R2", "busy write ignored", n_bad - bb, 0);

    // random jobs
    for (int k = 0; k < 24; k++) begin
      logic [15:0] c;
      logic [1:0]  sy;
      bit tc;
      bit ie;
      bit sf;
      int n;
      sy = 2'($urandom_range(2));
      sf = ($urandom_range(3) == 0);
      tc = (sy == 2'b00 || sf) ? 1'($urandom_range(1)) : 1'b1;
      ie = 1'($urandom_range(1));
      n  = $urandom_range(1, 4);
      c = mk_ctrl(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                  1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                  tc, ie, sy, sf, 1'b1, 1'($urandom_range(1)));
      dma_req = 1'b1;
      run_job(c, 20'($urandom), 20'($urandom), 16'(n), n, (tc && ie) ? 1 : 0, "R8");
      dma_req = 1'b0;
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule